// File: doc/BRIEF.md
# SDRAM Command Decoder

This block sits on the device side of a single-data-rate synchronous DRAM interface. It samples the control strobes, the clock enable, the bank bits and the multiplexed address bus on every rising clock edge. From them it produces a registered one-hot command indication and the fields each command carries: the row to open, the column to access, the auto-precharge request, the precharge-all request and the mode-register opcode. Address bit 10 does two jobs. On a column access it requests auto precharge. On a precharge it selects all banks.

The block also turns the per-byte data-mask inputs into two enables with different delays. The write byte enable follows the mask in the same cycle. The read output enable follows the mask two clock edges later. A mode load that arrives with address bit 12 set still stores its opcode, and it also sets a protocol-error flag that stays set until reset.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: While `sel_n` is high at a sampling edge, the next command output is INHIBIT (`cmd_onehot[0]`), whatever the other inputs are.
- R2: With `sel_n` low and `clk_en` high, the strobes {`rowstb_n`,`colstb_n`,`wren_n`} decode as follows: 111 to NOP (bit 1), 011 to ACTIVE (bit 2), 101 to READ (bit 3), 100 to WRITE (bit 4), 110 to BURST TERMINATE (bit 5), 010 to PRECHARGE (bit 6), 001 to AUTO REFRESH (bit 7), 000 to LOAD MODE (bit 9).
- R3: With `sel_n` low and `clk_en` low, strobes 001 decode as SELF REFRESH (bit 8). Every other strobe pattern decodes as NOP (bit 1).
- R4: `cmd_onehot` is registered. It shows the command sampled at the previous edge, exactly one of its 10 bits is set, and reset leaves it at INHIBIT.
- R5: ACTIVE loads `row` from `addr_in[12:0]` and `bank` from `bank_in`.
- R6: READ and WRITE load `col` from `addr_in[9:0]`, `auto_pre` from `addr_in[10]` and `bank` from `bank_in`.
- R7: PRECHARGE loads `pre_all` from `addr_in[10]`. It loads `bank` from `bank_in` only when `addr_in[10]` is 0. When `addr_in[10]` is 1, `bank` keeps its value.
- R8: LOAD MODE loads `mode_op` from `addr_in[11:0]`. If `addr_in[12]` is 1, it also sets `proto_err`, which stays at 1 until reset.
- R9: Each field register (`row`, `col`, `bank`, `auto_pre`, `pre_all`, `mode_op`) keeps its value under every command that does not load it, INHIBIT included.
- R10: `wr_byte_en[i]` equals the inverse of `byte_mask[i]` in the same cycle, under any command.
- R11: `rd_oe[i]` equals the inverse of `byte_mask[i]` sampled two edges earlier.
- R12: A synchronous active-low reset clears `row`, `col`, `bank`, `auto_pre`, `pre_all`, `mode_op`, `proto_err` and `rd_oe` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_n | input | 1 | Device select, active low |
| rowstb_n | input | 1 | Row strobe, active low |
| colstb_n | input | 1 | Column strobe, active low |
| wren_n | input | 1 | Write strobe, active low |
| clk_en | input | 1 | Clock enable |
| bank_in | input | 2 | Bank address |
| addr_in | input | 13 | Multiplexed address bus |
| byte_mask | input | 2 | Per-byte data mask, high masks the byte |
| cmd_onehot | output | 10 | Registered one-hot command |
| bank | output | 2 | Bank of the last ACTIVE, READ, WRITE or single-bank PRECHARGE |
| row | output | 13 | Row of the last ACTIVE |
| col | output | 10 | Column of the last READ or WRITE |
| auto_pre | output | 1 | Auto-precharge request of the last READ or WRITE |
| pre_all | output | 1 | All-bank flag of the last PRECHARGE |
| mode_op | output | 12 | Opcode of the last LOAD MODE |
| proto_err | output | 1 | Sticky flag for a LOAD MODE with address bit 12 set |
| wr_byte_en | output | 2 | Same-cycle write byte enable |
| rd_oe | output | 2 | Read output enable, two edges behind the mask |

## Verification
The command one-hot and every field register change one edge after the inputs are sampled. The bench therefore drives inputs on a falling edge and checks them on the next falling edge, after exactly one rising edge. The write byte enable is combinational, so it is checked a nanosecond after the mask changes, before any rising edge. The read output enable is checked one edge after the mask pulse, where it must still hold its old value, then at the second edge, where it must follow the mask, then at the third edge, where it must return. A one-cycle error in the read delay shows up in either direction.

// File: rtl/sdram_dec_pkg.sv
// Package: shared command encoding for the SDRAM command decoder.
// The command index is also the bit position in the one-hot output.
package sdram_dec_pkg;
    localparam int NCMD  = 10;
    localparam int CMD_W = $clog2(NCMD);

    typedef enum logic [CMD_W-1:0] {
        C_INHIBIT  = 4'd0,
        C_NOP      = 4'd1,
        C_ACTIVE   = 4'd2,
        C_READ     = 4'd3,
        C_WRITE    = 4'd4,
        C_BTERM    = 4'd5,
        C_PRECH    = 4'd6,
        C_AREF     = 4'd7,
        C_SREF     = 4'd8,
        C_LOADMODE = 4'd9
    } cmd_e;
endpackage

// File: rtl/sdram_cmd_classify.sv
// Module: sdram_cmd_classify
// Does: a purely combinational decode of the select, strobe and clock-enable
//       levels into a command code.
// Assumes: inputs are already synchronous to the sampling clock; the result
//          is registered downstream.
module sdram_cmd_classify
    import sdram_dec_pkg::*;
(
    input  logic sel_n,
    input  logic rowstb_n,
    input  logic colstb_n,
    input  logic wren_n,
    input  logic clk_en,
    output cmd_e cmd
);
    // Purpose: map select, clock enable and strobe pattern to one command.
    always_comb begin
        cmd = C_NOP;
        if (sel_n) begin
            cmd = C_INHIBIT;
        end else if (!clk_en) begin
            // Only the refresh pattern is meaningful while clock enable is low.
            if ({rowstb_n, colstb_n, wren_n} == 3'b001) cmd = C_SREF;
            else                                          cmd = C_NOP;
        end else begin
            case ({rowstb_n, colstb_n, wren_n})
                3'b111:  cmd = C_NOP;
                3'b011:  cmd = C_ACTIVE;
                3'b101:  cmd = C_READ;
                3'b100:  cmd = C_WRITE;
                3'b110:  cmd = C_BTERM;
                3'b010:  cmd = C_PRECH;
                3'b001:  cmd = C_AREF;
                default: cmd = C_LOADMODE;
            endcase
        end
    end

    // R3: with clock enable low only NOP, SELF REFRESH or INHIBIT can result.
    always_comb begin
        if (!clk_en) begin
            p_cke_low_r3: assert (cmd == C_NOP || cmd == C_SREF || cmd == C_INHIBIT);
        end
    end
endmodule

// File: rtl/sdram_addr_fields.sv
// Module: sdram_addr_fields
// Does: loads the address-derived fields only on the commands that own them,
//       and keeps the sticky protocol-error flag.
// Assumes: cmd is the combinational decode of the same cycle's inputs;
//          COL_W <= AP_BIT < MODE_W < ROW_W.
module sdram_addr_fields
    import sdram_dec_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int BA_W   = 2,
    parameter int MODE_W = 12,
    parameter int AP_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic [BA_W-1:0]   bank_in,
    input  logic [ROW_W-1:0]  addr_in,
    output logic [BA_W-1:0]   bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col,
    output logic              auto_pre,
    output logic              pre_all,
    output logic [MODE_W-1:0] mode_op,
    output logic              proto_err
);
    localparam int RSV_BIT = MODE_W;   // must be low during a mode load

    logic is_colacc;
    logic ap_flag;
    assign is_colacc = (cmd == C_READ) || (cmd == C_WRITE);
    assign ap_flag   = addr_in[AP_BIT];

    // Purpose: row address register, loaded by ACTIVE.
    always_ff @(posedge clk) begin
        if (!rst_n)                row <= '0;
        else if (cmd == C_ACTIVE)  row <= addr_in;
    end

    // Purpose: bank register, loaded by ACTIVE, column access or single-bank precharge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank <= '0;
        else if (cmd == C_ACTIVE || is_colacc || (cmd == C_PRECH && !ap_flag))
            bank <= bank_in;
    end

    // Purpose: column and auto-precharge registers, loaded by READ or WRITE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col      <= '0;
            auto_pre <= 1'b0;
        end else if (is_colacc) begin
            col      <= addr_in[COL_W-1:0];
            auto_pre <= ap_flag;
        end
    end

    // Purpose: all-bank flag register, loaded by PRECHARGE.
    always_ff @(posedge clk) begin
        if (!rst_n)               pre_all <= 1'b0;
        else if (cmd == C_PRECH)  pre_all <= ap_flag;
    end

    // Purpose: mode opcode register and sticky reserved-bit error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_op   <= '0;
            proto_err <= 1'b0;
        end else if (cmd == C_LOADMODE) begin
            mode_op <= addr_in[MODE_W-1:0];
            if (addr_in[RSV_BIT]) proto_err <= 1'b1;
        end
    end

    // R9: the row register holds unless an ACTIVE is decoded.
    p_row_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != C_ACTIVE) |=> $stable(row));
    // R9: the opcode holds unless a LOAD MODE is decoded.
    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != C_LOADMODE) |=> $stable(mode_op));
    // R7: an all-bank precharge leaves the bank register alone.
    p_preall_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == C_PRECH && ap_flag) |=> $stable(bank));
    // R8: once set, the error flag stays set.
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
endmodule

// File: rtl/sdram_mask_pipe.sv
// Module: sdram_mask_pipe
// Does: turns per-byte masks into a same-cycle write enable and a read
//       output enable delayed by RD_LAT edges.
// Assumes: RD_LAT >= 2; the mask is sampled every cycle whatever the command.
module sdram_mask_pipe #(
    parameter int LANES  = 2,
    parameter int RD_LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] byte_mask,
    output logic [LANES-1:0] wr_byte_en,
    output logic [LANES-1:0] rd_oe
);
    localparam int TOP = RD_LAT - 1;

    // Purpose: the write path uses the mask with no delay.
    assign wr_byte_en = ~byte_mask;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [TOP:0] stage;

        // Purpose: per-lane shift register carrying the read enable forward.
        always_ff @(posedge clk) begin
            if (!rst_n) stage <= '0;
            else        stage <= {stage[TOP-1:0], ~byte_mask[g]};
        end
        assign rd_oe[g] = stage[TOP];

        if (RD_LAT == 2) begin : g_chk
            // R11: an unmasked byte enables the read output two edges later.
            p_rdoe_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
                !byte_mask[g] |=> ##1 rd_oe[g]);
            // R11: a masked byte disables the read output two edges later.
            p_rdoe_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
                byte_mask[g] |=> ##1 !rd_oe[g]);
        end
    end
endmodule

// File: rtl/sdram_cmd_decoder.sv
// Module: sdram_cmd_decoder (top)
// Does: samples the device-side control bus each rising edge and produces a
//       registered one-hot command, the address fields and mask enables.
// Assumes: single-data-rate bus, x16 organisation with two byte lanes.
module sdram_cmd_decoder
    import sdram_dec_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int BA_W   = 2,
    parameter int MODE_W = 12,
    parameter int LANES  = 2,
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              rowstb_n,
    input  logic              colstb_n,
    input  logic              wren_n,
    input  logic              clk_en,
    input  logic [BA_W-1:0]   bank_in,
    input  logic [ROW_W-1:0]  addr_in,
    input  logic [LANES-1:0]  byte_mask,
    output logic [NCMD-1:0]   cmd_onehot,
    output logic [BA_W-1:0]   bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col,
    output logic              auto_pre,
    output logic              pre_all,
    output logic [MODE_W-1:0] mode_op,
    output logic              proto_err,
    output logic [LANES-1:0]  wr_byte_en,
    output logic [LANES-1:0]  rd_oe
);
    localparam int AP_BIT = 10;

    cmd_e cmd_now;

    sdram_cmd_classify u_classify (
        .sel_n    (sel_n),
        .rowstb_n (rowstb_n),
        .colstb_n (colstb_n),
        .wren_n   (wren_n),
        .clk_en   (clk_en),
        .cmd      (cmd_now)
    );

    // Purpose: register the decoded command as a one-hot vector.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_onehot <= NCMD'(1) << C_INHIBIT;
        else        cmd_onehot <= NCMD'(1) << cmd_now;
    end

    sdram_addr_fields #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .BA_W   (BA_W),
        .MODE_W (MODE_W),
        .AP_BIT (AP_BIT)
    ) u_fields (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd_now),
        .bank_in   (bank_in),
        .addr_in   (addr_in),
        .bank      (bank),
        .row       (row),
        .col       (col),
        .auto_pre  (auto_pre),
        .pre_all   (pre_all),
        .mode_op   (mode_op),
        .proto_err (proto_err)
    );

    sdram_mask_pipe #(
        .LANES  (LANES),
        .RD_LAT (RD_LAT)
    ) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_mask  (byte_mask),
        .wr_byte_en (wr_byte_en),
        .rd_oe      (rd_oe)
    );

    // R4: exactly one command bit is set every cycle.
    p_one_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cmd_onehot) == 1);
    // R1: a deselected bus yields INHIBIT one edge later.
    p_inhibit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> cmd_onehot[C_INHIBIT]);
    // R3: the refresh pattern with clock enable low yields SELF REFRESH.
    p_sref_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !clk_en && !rowstb_n && !colstb_n && wren_n) |=> cmd_onehot[C_SREF]);
endmodule

// File: tb/sdram_cmd_decoder_bench.sv
// Bench for sdram_cmd_decoder: a vector walk over the command encodings,
// then directed tests for the fields, the masks and reset.
module sdram_cmd_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sel_n, rowstb_n, colstb_n, wren_n, clk_en;
    logic [1:0]  bank_in;
    logic [12:0] addr_in;
    logic [1:0]  byte_mask;
    logic [9:0]  cmd_onehot;
    logic [1:0]  bank;
    logic [12:0] row;
    logic [9:0]  col;
    logic        auto_pre, pre_all, proto_err;
    logic [11:0] mode_op;
    logic [1:0]  wr_byte_en, rd_oe;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    sdram_cmd_decoder u_sdram_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rowstb_n(rowstb_n),
        .colstb_n(colstb_n), .wren_n(wren_n), .clk_en(clk_en),
        .bank_in(bank_in), .addr_in(addr_in), .byte_mask(byte_mask),
        .cmd_onehot(cmd_onehot), .bank(bank), .row(row), .col(col),
        .auto_pre(auto_pre), .pre_all(pre_all), .mode_op(mode_op),
        .proto_err(proto_err), .wr_byte_en(wr_byte_en), .rd_oe(rd_oe)
    );

    // {sel_n, rowstb_n, colstb_n, wren_n, clk_en, expected command index}
    localparam logic [8:0] VEC [0:12] = '{
        {5'b1_000_1, 4'd0},   // R1 deselected, mode-load pattern
        {5'b1_111_0, 4'd0},   // R1 deselected, clock enable low
        {5'b0_111_1, 4'd1},   // R2 NOP
        {5'b0_011_1, 4'd2},   // R2 ACTIVE
        {5'b0_101_1, 4'd3},   // R2 READ
        {5'b0_100_1, 4'd4},   // R2 WRITE
        {5'b0_110_1, 4'd5},   // R2 BURST TERMINATE
        {5'b0_010_1, 4'd6},   // R2 PRECHARGE
        {5'b0_001_1, 4'd7},   // R2 AUTO REFRESH
        {5'b0_001_0, 4'd8},   // R3 SELF REFRESH
        {5'b0_000_1, 4'd9},   // R2 LOAD MODE
        {5'b0_011_0, 4'd1},   // R3 ACTIVE pattern, clock enable low
        {5'b0_100_0, 4'd1}    // R3 WRITE pattern, clock enable low
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one command on a falling edge, then wait one rising edge.
    task automatic issue(input logic [3:0] strobes, input logic cke,
                         input logic [1:0] ba, input logic [12:0] a);
        @(negedge clk);
        {sel_n, rowstb_n, colstb_n, wren_n} = strobes;
        clk_en  = cke;
        bank_in = ba;
        addr_in = a;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {sel_n, rowstb_n, colstb_n, wren_n} = 4'b1111;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic check_reset_state(input string tag);
        check({tag, " cmd INHIBIT"}, cmd_onehot, 10'b1);
        check({tag, " row"},  row, 0);
        check({tag, " col"},  col, 0);
        check({tag, " bank"}, bank, 0);
        check({tag, " flags"}, {auto_pre, pre_all, proto_err}, 0);
        check({tag, " mode_op"}, mode_op, 0);
        check({tag, " rd_oe"}, rd_oe, 0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0;
        {sel_n, rowstb_n, colstb_n, wren_n} = 4'b1111;
        clk_en = 1'b1; bank_in = '0; addr_in = '0; byte_mask = 2'b11;
        repeat (3) @(negedge clk);
        // R12 R4: reset state
        check_reset_state("R12");
        rst_n = 1'b1;

        // R1 R2 R3 R4: encoding table walk
        for (int i = 0; i < 13; i++) begin
            issue(VEC[i][8:5], VEC[i][4], 2'd0, 13'd0);
            check($sformatf("R2 vector %0d one-hot", i), cmd_onehot, 32'd1 << VEC[i][3:0]);
        end

        // R5: ACTIVE captures row and bank
        issue(4'b0011, 1'b1, 2'd2, 13'h1ABC);
        check("R5 row", row, 13'h1ABC);
        check("R5 bank", bank, 2);

        // R1 R9: INHIBIT with an ACTIVE pattern changes nothing
        issue(4'b1011, 1'b1, 2'd1, 13'h0555);
        check("R1 cmd", cmd_onehot, 10'b1);
        check("R9 row held", row, 13'h1ABC);
        check("R9 bank held", bank, 2);

        // R6: READ with bit 10 high
        issue(4'b0101, 1'b1, 2'd1, 13'h1F23);
        check("R6 read col", col, 10'h323);
        check("R6 read auto_pre", auto_pre, 1);
        check("R6 read bank", bank, 1);
        check("R9 row held on read", row, 13'h1ABC);

        // R6: WRITE with bit 10 low
        issue(4'b0100, 1'b1, 2'd3, 13'h00A5);
        check("R6 write col", col, 10'h0A5);
        check("R6 write auto_pre", auto_pre, 0);
        check("R6 write bank", bank, 3);

        // R7: all-bank precharge leaves bank alone
        issue(4'b0010, 1'b1, 2'd0, 13'h0400);
        check("R7 pre_all set", pre_all, 1);
        check("R7 bank ignored", bank, 3);
        check("R9 col held", col, 10'h0A5);

        // R7: single-bank precharge
        issue(4'b0010, 1'b1, 2'd1, 13'h0000);
        check("R7 pre_all clear", pre_all, 0);
        check("R7 bank loaded", bank, 1);

        // R8: clean mode load
        issue(4'b0000, 1'b1, 2'd0, 13'h0233);
        check("R8 mode_op", mode_op, 12'h233);
        check("R8 no error", proto_err, 0);

        // R8: mode load with bit 12 set
        issue(4'b0000, 1'b1, 2'd0, 13'h1031);
        check("R8 opcode still captured", mode_op, 12'h031);
        check("R8 error set", proto_err, 1);

        // R8 R9: error sticky, opcode held through NOP
        issue(4'b0111, 1'b1, 2'd2, 13'h0FFF);
        check("R8 error sticky", proto_err, 1);
        check("R9 mode held", mode_op, 12'h031);

        // R10: same-cycle write byte enable
        @(negedge clk);
        byte_mask = 2'b10;
        #1;
        check("R10 wr_byte_en", wr_byte_en, 2'b01);
        byte_mask = 2'b00;
        #1;
        check("R10 wr_byte_en all", wr_byte_en, 2'b11);

        // R11: two-edge read enable delay
        repeat (2) @(negedge clk);
        check("R11 settled", rd_oe, 2'b11);
        byte_mask = 2'b01;
        @(negedge clk);
        byte_mask = 2'b00;
        check("R11 one edge, unchanged", rd_oe, 2'b11);
        @(negedge clk);
        check("R11 two edges, follows mask", rd_oe, 2'b10);
        @(negedge clk);
        check("R11 three edges, restored", rd_oe, 2'b11);

        // R12: reset mid-run clears everything, sticky error included
        do_reset();
        check_reset_state("R12 mid-run");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule